// File: doc/BRIEF.md
# Per-Hart Wired Interrupt Delivery Controller

This block keeps one delivery context for every hart that takes its external interrupt as a wire. Each context has a delivery-enable bit, a force bit and a priority threshold that software can write, plus two read-only views: the top interrupt and the claim. For each context a picker scans all sources. It keeps those that are pending, enabled, aimed at that hart and under the threshold, and picks the most urgent one. A lower priority number is more urgent. The hart's interrupt line is then driven from that result, the domain enable input and the context bits.

The block also holds the per-source target (hart index and priority) and the pending state. Source sensing logic outside the block supplies one set pulse per detected event and a hold level for sources that stay asserted. Software works through a simple register port. The port takes a request in any cycle and returns a response in the next cycle. It has no back-pressure: the block never stalls, so the requester needs no ready signal. A claim read acknowledges the chosen source in the same cycle it is answered.

Top module: `hart_irq_deliver`

## Requirements
- R1: Every request (cfg_req_i high at a rising edge) gets cfg_rsp_valid_o high for exactly the following cycle. Read data is returned in that cycle. Writes and errored requests return rdata 0.
- R2: Address map (byte address, 12 bits). When bit 11 is 0, context c sits at 32*c. Its words are: 0x00 delivery enable, 0x04 force, 0x08 threshold, 0x18 top interrupt (read-only), 0x1C claim (read-only). When bit 11 is 1, the target of source s sits at 0x800 + 4*s. These requests are errors: a misaligned address, any other context offset, a context number at or above NHART, a source 0 or above NSRC, and a write to 0x18 or 0x1C. An error sets cfg_rsp_err_o, returns rdata 0 and changes no state.
- R3: Delivery enable and force keep only bit 0 of the write data. The threshold keeps bits [PRIO_W-1:0].
- R4: A target word holds the priority in bits [PRIO_W-1:0] and the hart index in bits [16+HIDX_W-1:16]. All other bits read 0. A written priority of 0 is stored as 1. After reset every target reads as priority 1, hart 0.
- R5: A source is eligible for context c when all of these hold: it is pending, its enable input is 1, its hart index equals c, and either the threshold is 0 or its priority is strictly below the threshold.
- R6: Among eligible sources the smallest priority wins, and a tie goes to the smallest source number. The top word reads (id << 16) | priority, or 0 when nothing is eligible.
- R7: irq_o[c] is a register. One cycle after the inputs it depends on, it equals dom_en_i AND delivery-enable AND (force OR top word nonzero).
- R8: A claim read returns the top word and clears the winner's pending bit, except when src_hold_i of that source is high, in which case the bit stays set. A claim with no eligible source returns 0 and clears force.
- R9: A high src_set_i bit makes the source pending from the next cycle. A set wins over a claim of the same source in the same cycle.
- R10: After reset all pending bits, enables, forces, thresholds and interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dom_en_i | input | 1 | Domain-wide delivery enable |
| src_en_i | input | NSRC | Source enable, bit i is source i+1 |
| src_set_i | input | NSRC | Pending set pulse, bit i is source i+1 |
| src_hold_i | input | NSRC | Source still asserted (re-pend on claim) |
| cfg_req_i | input | 1 | Register request strobe |
| cfg_we_i | input | 1 | 1 for write, 0 for read |
| cfg_addr_i | input | 12 | Byte address |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rsp_valid_o | output | 1 | Response valid |
| cfg_rsp_err_o | output | 1 | Response is an error |
| cfg_rsp_rdata_o | output | 32 | Read data |
| irq_o | output | NHART | Interrupt line per hart |

## Verification
A request sampled at edge E has its response on the ports after E. Any state it changes (a register, a pending bit, a force clear) is visible in the top word computed for a request at E+1. The interrupt line shows that state change only after E+1, because it has one more register stage. The bench drives every input on the falling edge and reads the response at the falling edge right after the request edge. Before it compares irq_o, it waits one further rising edge after the last write, set pulse or enable change. The sweeps compare every top and claim read against an arithmetic model of the eligibility and ordering rules.

// File: rtl/hid_pkg.sv
package hid_pkg;
  localparam int REG_ADDR_W  = 12;
  localparam int CTX_FIELD_W = 6;
  localparam int SRC_FIELD_W = 9;
  localparam int TOP_ID_LSB  = 16;
  localparam int TGT_HART_LSB = 16;

  typedef enum logic [2:0] {
    CW_DELIV  = 3'd0,
    CW_FORCE  = 3'd1,
    CW_THRESH = 3'd2,
    CW_TOP    = 3'd6,
    CW_CLAIM  = 3'd7
  } ctx_word_e;

  function automatic logic word_known(input logic [2:0] w);
    return (w == CW_DELIV) || (w == CW_FORCE) || (w == CW_THRESH) ||
           (w == CW_TOP) || (w == CW_CLAIM);
  endfunction

  function automatic logic word_readonly(input logic [2:0] w);
    return (w == CW_TOP) || (w == CW_CLAIM);
  endfunction
endpackage

// File: rtl/hid_src.sv
module hid_src #(
  parameter int NSRC   = 15,
  parameter int PRIO_W = 3,
  parameter int HIDX_W = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NSRC-1:0]                wr_sel_i,
  input  logic [HIDX_W-1:0]              whart_i,
  input  logic [PRIO_W-1:0]              wprio_i,
  input  logic [NSRC-1:0]                set_i,
  input  logic [NSRC-1:0]                hold_i,
  input  logic [NSRC-1:0]                clr_i,
  output logic [NSRC-1:0]                pend_o,
  output logic [NSRC-1:0][HIDX_W-1:0]    hart_o,
  output logic [NSRC-1:0][PRIO_W-1:0]    prio_o
);
  logic [PRIO_W-1:0] prio_fix;
  assign prio_fix = (wprio_i == '0) ? PRIO_W'(1) : wprio_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hart_o[i] <= '0;
        prio_o[i] <= PRIO_W'(1);
        pend_o[i] <= 1'b0;
      end else begin
        if (wr_sel_i[i]) begin
          hart_o[i] <= whart_i;
          prio_o[i] <= prio_fix;
        end
        pend_o[i] <= set_i[i] | (pend_o[i] & ~clr_i[i]) | (clr_i[i] & hold_i[i]);
      end
    end
  end
endmodule

// File: rtl/hid_pick.sv
module hid_pick
  import hid_pkg::*;
#(
  parameter int          NSRC   = 15,
  parameter int          PRIO_W = 3,
  parameter int          HIDX_W = 6,
  parameter int unsigned CTX    = 0
) (
  input  logic [NSRC-1:0]             pend_i,
  input  logic [NSRC-1:0]             en_i,
  input  logic [NSRC-1:0][HIDX_W-1:0] hart_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [NSRC-1:0]             grant_o,
  output logic [31:0]                 top_o
);
  localparam int SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]   elig;
  logic              found;
  logic [PRIO_W-1:0] best_prio;
  logic [SIDX_W-1:0] best_idx;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign elig[i] = pend_i[i] & en_i[i] & (hart_i[i] == HIDX_W'(CTX)) &
                     ((thr_i == '0) | (prio_i[i] < thr_i));
  end

  // Upward scan with strict compare: on equal priority the lower index stays.
  always_comb begin
    found     = 1'b0;
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || (prio_i[i] < best_prio))) begin
        found     = 1'b1;
        best_prio = prio_i[i];
        best_idx  = SIDX_W'(i);
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_grant
    assign grant_o[i] = found && (best_idx == SIDX_W'(i));
  end

  assign top_o = found ? (((32'(best_idx) + 32'd1) << TOP_ID_LSB) | 32'(best_prio)) : 32'd0;
endmodule

// File: rtl/hid_ctx.sv
module hid_ctx #(
  parameter int PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_de_i,
  input  logic              wr_force_i,
  input  logic              wr_thr_i,
  input  logic              wbit_i,
  input  logic [PRIO_W-1:0] wthr_i,
  input  logic              clr_force_i,
  input  logic              dom_en_i,
  input  logic              top_nz_i,
  output logic              de_o,
  output logic              force_o,
  output logic [PRIO_W-1:0] thr_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o    <= 1'b0;
      force_o <= 1'b0;
      thr_o   <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (wr_de_i) de_o <= wbit_i;
      if (wr_force_i) force_o <= wbit_i;
      else if (clr_force_i) force_o <= 1'b0;
      if (wr_thr_i) thr_o <= wthr_i;
      irq_o <= dom_en_i & de_o & (force_o | top_nz_i);
    end
  end
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int NSRC   = 15,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3,
  parameter int HIDX_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dom_en_i,
  input  logic [NSRC-1:0]       src_en_i,
  input  logic [NSRC-1:0]       src_set_i,
  input  logic [NSRC-1:0]       src_hold_i,
  input  logic                  cfg_req_i,
  input  logic                  cfg_we_i,
  input  logic [REG_ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]           cfg_wdata_i,
  output logic                  cfg_rsp_valid_o,
  output logic                  cfg_rsp_err_o,
  output logic [31:0]           cfg_rsp_rdata_o,
  output logic [NHART-1:0]      irq_o
);
  logic                   is_tgt, aligned, tgt_ok, ctx_ok, err, go;
  logic [SRC_FIELD_W-1:0] tgt_id;
  logic [CTX_FIELD_W-1:0] ctx_f;
  logic [2:0]             word;
  logic                   unused_wdata;

  logic [NSRC-1:0]              pend;
  logic [NSRC-1:0][HIDX_W-1:0]  tgt_hart;
  logic [NSRC-1:0][PRIO_W-1:0]  tgt_prio;
  logic [NSRC-1:0]              tgt_sel, clr_vec;

  logic [NHART-1:0]             de_v, force_v, clr_force, claim_h;
  logic [NHART-1:0]             wr_de, wr_force, wr_thr;
  logic [NHART-1:0][PRIO_W-1:0] thr_v;
  logic [NHART-1:0][31:0]       top_v;
  logic [NHART-1:0][NSRC-1:0]   grant_v;
  logic [31:0]                  rd;

  assign unused_wdata = ^cfg_wdata_i;

  assign aligned = (cfg_addr_i[1:0] == 2'b00);
  assign is_tgt  = cfg_addr_i[11];
  assign tgt_id  = cfg_addr_i[10:2];
  assign ctx_f   = cfg_addr_i[10:5];
  assign word    = cfg_addr_i[4:2];
  assign tgt_ok  = (tgt_id != '0) && (32'(tgt_id) <= NSRC);
  assign ctx_ok  = (32'(ctx_f) < NHART);
  assign err = !aligned ||
               (is_tgt ? !tgt_ok
                       : (!ctx_ok || !word_known(word) || (cfg_we_i && word_readonly(word))));
  assign go  = cfg_req_i && !err;

  for (genvar i = 0; i < NSRC; i++) begin : g_tsel
    assign tgt_sel[i] = go && cfg_we_i && is_tgt && (32'(tgt_id) == i + 1);
  end

  always_comb begin
    clr_vec = '0;
    for (int h = 0; h < NHART; h++) begin
      if (claim_h[h]) clr_vec = clr_vec | grant_v[h];
    end
  end

  hid_src #(.NSRC(NSRC), .PRIO_W(PRIO_W), .HIDX_W(HIDX_W)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (tgt_sel),
    .whart_i  (cfg_wdata_i[TGT_HART_LSB +: HIDX_W]),
    .wprio_i  (cfg_wdata_i[PRIO_W-1:0]),
    .set_i    (src_set_i),
    .hold_i   (src_hold_i),
    .clr_i    (clr_vec),
    .pend_o   (pend),
    .hart_o   (tgt_hart),
    .prio_o   (tgt_prio)
  );

  for (genvar h = 0; h < NHART; h++) begin : g_ctx
    logic sel_h;
    assign sel_h       = go && !is_tgt && (32'(ctx_f) == h);
    assign wr_de[h]    = sel_h && cfg_we_i && (word == CW_DELIV);
    assign wr_force[h] = sel_h && cfg_we_i && (word == CW_FORCE);
    assign wr_thr[h]   = sel_h && cfg_we_i && (word == CW_THRESH);
    assign claim_h[h]  = sel_h && !cfg_we_i && (word == CW_CLAIM);
    assign clr_force[h] = claim_h[h] && (top_v[h] == 32'd0);

    hid_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .HIDX_W(HIDX_W), .CTX(h)) u_pick (
      .pend_i  (pend),
      .en_i    (src_en_i),
      .hart_i  (tgt_hart),
      .prio_i  (tgt_prio),
      .thr_i   (thr_v[h]),
      .grant_o (grant_v[h]),
      .top_o   (top_v[h])
    );

    hid_ctx #(.PRIO_W(PRIO_W)) u_ctx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_de_i     (wr_de[h]),
      .wr_force_i  (wr_force[h]),
      .wr_thr_i    (wr_thr[h]),
      .wbit_i      (cfg_wdata_i[0]),
      .wthr_i      (cfg_wdata_i[PRIO_W-1:0]),
      .clr_force_i (clr_force[h]),
      .dom_en_i    (dom_en_i),
      .top_nz_i    (top_v[h] != 32'd0),
      .de_o        (de_v[h]),
      .force_o     (force_v[h]),
      .thr_o       (thr_v[h]),
      .irq_o       (irq_o[h])
    );
  end

  always_comb begin
    rd = 32'd0;
    if (is_tgt) begin
      for (int i = 0; i < NSRC; i++) begin
        if (32'(tgt_id) == i + 1)
          rd = (32'(tgt_hart[i]) << TGT_HART_LSB) | 32'(tgt_prio[i]);
      end
    end else begin
      for (int h = 0; h < NHART; h++) begin
        if (32'(ctx_f) == h) begin
          case (word)
            CW_DELIV:          rd = 32'(de_v[h]);
            CW_FORCE:          rd = 32'(force_v[h]);
            CW_THRESH:         rd = 32'(thr_v[h]);
            CW_TOP, CW_CLAIM:  rd = top_v[h];
            default:           rd = 32'd0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rsp_valid_o <= 1'b0;
      cfg_rsp_err_o   <= 1'b0;
      cfg_rsp_rdata_o <= 32'd0;
    end else begin
      cfg_rsp_valid_o <= cfg_req_i;
      cfg_rsp_err_o   <= cfg_req_i && err;
      cfg_rsp_rdata_o <= (go && !cfg_we_i) ? rd : 32'd0;
    end
  end
endmodule

// File: rtl/hart_irq_deliver_chk.sv
module hart_irq_deliver_chk #(
  parameter int NSRC   = 15,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          dom_en_i,
  input logic                          cfg_req_i,
  input logic                          cfg_we_i,
  input logic                          cfg_rsp_valid_o,
  input logic                          cfg_rsp_err_o,
  input logic [31:0]                   cfg_rsp_rdata_o,
  input logic [NHART-1:0]              irq_o,
  input logic [NSRC-1:0][PRIO_W-1:0]   tgt_prio
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i |=> cfg_rsp_valid_o);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_req_i |=> !cfg_rsp_valid_o);

  assert_write_rdata_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_we_i) |=> (cfg_rsp_rdata_o == 32'd0));

  assert_err_rdata_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rsp_err_o |-> (cfg_rsp_valid_o && (cfg_rsp_rdata_o == 32'd0)));

  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    assert_prio_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_prio[i] != '0);
  end

  for (genvar h = 0; h < NHART; h++) begin : g_line
    assert_line_needs_domain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[h] |-> $past(dom_en_i));
  end
endmodule

bind hart_irq_deliver hart_irq_deliver_chk #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .dom_en_i        (dom_en_i),
  .cfg_req_i       (cfg_req_i),
  .cfg_we_i        (cfg_we_i),
  .cfg_rsp_valid_o (cfg_rsp_valid_o),
  .cfg_rsp_err_o   (cfg_rsp_err_o),
  .cfg_rsp_rdata_o (cfg_rsp_rdata_o),
  .irq_o           (irq_o),
  .tgt_prio        (tgt_prio)
);

// File: tb/hart_irq_deliver_tb_top.sv
`timescale 1ns/1ps
module hart_irq_deliver_tb_top;
  localparam int NSRC = 15;
  localparam int NHART = 2;
  localparam int PRIO_W = 3;
  localparam int HIDX_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dom_en = 1'b0;
  logic [NSRC-1:0] src_en = '0, src_set = '0, src_hold = '0;
  logic cfg_req = 1'b0, cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NHART-1:0] irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  int m_hart [1:NSRC];
  int m_prio [1:NSRC];
  bit m_pend [1:NSRC];
  bit m_en   [1:NSRC];
  bit m_de [NHART];
  bit m_force [NHART];
  int m_thr [NHART];
  bit m_dom;

  always #2 clk = ~clk;

  hart_irq_deliver #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W), .HIDX_W(HIDX_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dom_en_i(dom_en), .src_en_i(src_en),
    .src_set_i(src_set), .src_hold_i(src_hold), .cfg_req_i(cfg_req), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rsp_valid_o(rsp_valid),
    .cfg_rsp_err_o(rsp_err), .cfg_rsp_rdata_o(rsp_rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] m_top(input int h);
    bit found = 0;
    int bp = 0, bi = 0;
    for (int i = 1; i <= NSRC; i++) begin
      if (m_pend[i] && m_en[i] && m_hart[i] == h && (m_thr[h] == 0 || m_prio[i] < m_thr[h]) &&
          (!found || m_prio[i] < bp)) begin
        found = 1; bp = m_prio[i]; bi = i;
      end
    end
    return found ? ((32'(bi) << 16) | 32'(bp)) : 32'd0;
  endfunction

  function automatic logic m_irq(input int h);
    return m_dom && m_de[h] && (m_force[h] || m_top(h) != 0);
  endfunction

  // Entered and left at a falling edge; the request is sampled at the edge in between.
  task automatic bus(input bit we, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    checks++;
    if (rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL R1 rsp_valid act=%b exp=1", rsp_valid);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    bus(1'b1, a, d, rd, er);
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    bus(1'b0, a, 32'd0, rd, er);
    chk(tag, rd, exp);
  endtask

  task automatic errchk(input string tag, input bit we, input logic [11:0] a);
    logic [31:0] rd; logic er;
    bus(we, a, 32'hFFFF_FFFF, rd, er);
    chk(tag, {31'd0, er}, 32'd1);
    chk(tag, rd, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dom_en = 1'b0; src_en = '0; src_set = '0; src_hold = '0;
    m_dom = 0;
    for (int i = 1; i <= NSRC; i++) begin
      m_hart[i] = 0; m_prio[i] = 1; m_pend[i] = 0; m_en[i] = 0;
    end
    for (int h = 0; h < NHART; h++) begin
      m_de[h] = 0; m_force[h] = 0; m_thr[h] = 0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_tgt(input int s, input int hart, input int prio);
    wr(12'h800 + 12'(4 * s), (32'(hart) << 16) | 32'(prio));
    m_hart[s] = hart;
    m_prio[s] = (prio % 8 == 0) ? 1 : prio % 8;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    src_set = m;
    @(posedge clk); @(negedge clk);
    src_set = '0;
    for (int i = 1; i <= NSRC; i++) if (m[i-1]) m_pend[i] = 1;
  endtask

  task automatic apply_en(input logic [NSRC-1:0] m);
    src_en = m;
    for (int i = 1; i <= NSRC; i++) m_en[i] = m[i-1];
  endtask

  task automatic claim(input string tag, input int h, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    bus(1'b0, 12'(32 * h + 'h1C), 32'd0, rd, er);
    chk(tag, rd, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    do_reset();

    // R10 reset state
    chk("R10 irq", 32'(irq), 32'd0);
    for (int h = 0; h < NHART; h++) begin
      rdchk("R10 deliv", 12'(32 * h), 32'd0);
      rdchk("R10 force", 12'(32 * h + 4), 32'd0);
      rdchk("R10 thresh", 12'(32 * h + 8), 32'd0);
      rdchk("R10 top", 12'(32 * h + 'h18), 32'd0);
    end
    rdchk("R4 target reset", 12'h804, 32'd1);

    // R3 masking
    wr(12'h000, 32'hFFFF_FFFE); rdchk("R3 deliv bit0", 12'h000, 32'd0);
    wr(12'h004, 32'hFFFF_FFFF); rdchk("R3 force bit0", 12'h004, 32'd1);
    wr(12'h028, 32'hFFFF_FFFF); rdchk("R3 thresh mask", 12'h028, 32'd7);
    wr(12'h028, 32'd0); wr(12'h004, 32'd0);

    // R4 target encoding
    wr(12'h808, 32'd0);          rdchk("R4 prio0 to 1", 12'h808, 32'd1);
    wr(12'h808, 32'hFFFF_FFFF);  rdchk("R4 all ones", 12'h808, (32'd63 << 16) | 32'd7);
    wr(12'h83C, 32'h0001_0005);  rdchk("R4 last source", 12'h83C, 32'h0001_0005);

    // R2 errors and no state change
    errchk("R2 misaligned", 1'b1, 12'h005);
    rdchk("R2 force untouched", 12'h004, 32'd0);
    errchk("R2 bad offset", 1'b0, 12'h00C);
    errchk("R2 ctx range", 1'b1, 12'h040);
    errchk("R2 src0", 1'b1, 12'h800);
    errchk("R2 src range", 1'b0, 12'h840);
    errchk("R2 top write", 1'b1, 12'h018);
    errchk("R2 claim write", 1'b1, 12'h03C);
    rdchk("R2 ctx1 deliv untouched", 12'h020, 32'd0);

    // R6 tie and R5 threshold / enable
    do_reset();
    set_tgt(4, 1, 3); set_tgt(2, 1, 3); set_tgt(6, 1, 5);
    apply_en(15'h7FFF);
    pulse(15'b000_0000_0010_1010);
    rdchk("R6 tie lowest id", 12'h038, (32'd2 << 16) | 32'd3);
    wr(12'h028, 32'd3); m_thr[1] = 3;
    rdchk("R5 threshold blocks equal", 12'h038, 32'd0);
    wr(12'h028, 32'd4); m_thr[1] = 4;
    rdchk("R5 threshold passes lower", 12'h038, (32'd2 << 16) | 32'd3);
    apply_en(15'h7FFD);
    rdchk("R5 disabled skipped", 12'h038, (32'd4 << 16) | 32'd3);
    rdchk("R5 other hart empty", 12'h018, 32'd0);

    // R5 threshold sweep over every priority/threshold pair
    do_reset();
    apply_en(15'h0001);
    pulse(15'h0001);
    for (int p = 1; p < 8; p++) begin
      set_tgt(1, 0, p);
      for (int t = 0; t < 8; t++) begin
        wr(12'h008, 32'(t)); m_thr[0] = t;
        rdchk("R5 sweep", 12'h018, m_top(0));
      end
    end

    // R7 force alone, domain gating
    do_reset();
    wr(12'h000, 32'd1); wr(12'h004, 32'd1);
    dom_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 force raises line", 32'(irq), 32'b01);
    dom_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 domain off lowers line", 32'(irq), 32'b00);
    claim("R8 empty claim", 0, 32'd0);
    rdchk("R8 empty claim clears force", 12'h004, 32'd0);

    // R9 set wins over claim; R8 hold re-pends
    do_reset();
    set_tgt(3, 0, 2);
    apply_en(15'h7FFF);
    pulse(15'b000_0000_0000_0100);
    src_set = 15'b000_0000_0000_0100;
    claim("R9 claim during set", 0, (32'd3 << 16) | 32'd2);
    src_set = '0;
    rdchk("R9 set wins", 12'h018, (32'd3 << 16) | 32'd2);
    claim("R8 claim clears", 0, (32'd3 << 16) | 32'd2);
    rdchk("R8 pending cleared", 12'h018, 32'd0);
    set_tgt(5, 0, 2);
    pulse(15'b000_0000_0001_0000);
    src_hold = 15'b000_0000_0001_0000;
    claim("R8 claim held", 0, (32'd5 << 16) | 32'd2);
    rdchk("R8 hold re-pends", 12'h018, (32'd5 << 16) | 32'd2);
    src_hold = '0;
    claim("R8 claim released", 0, (32'd5 << 16) | 32'd2);
    rdchk("R8 released cleared", 12'h018, 32'd0);

    // Randomized near-exhaustive sweep with model
    for (int it = 0; it < 200; it++) begin
      do_reset();
      for (int s = 1; s <= NSRC; s++) begin
        v = rnd();
        set_tgt(s, int'(v % 3), int'((v >> 8) % 8));
      end
      apply_en(rnd()[NSRC-1:0]);
      pulse(rnd()[NSRC-1:0]);
      for (int h = 0; h < NHART; h++) begin
        v = rnd();
        wr(12'(32 * h + 8), v); m_thr[h] = int'(v % 8);
        v = rnd();
        wr(12'(32 * h), v); m_de[h] = v[0];
        v = rnd();
        wr(12'(32 * h + 4), v); m_force[h] = v[0];
      end
      v = rnd();
      dom_en = v[0]; m_dom = v[0];
      @(posedge clk); @(negedge clk);
      for (int h = 0; h < NHART; h++) begin
        chk("R7 sweep line", 32'(irq[h]), 32'(m_irq(h)));
        rdchk("R6 sweep top", 12'(32 * h + 'h18), m_top(h));
      end
      for (int k = 0; k <= NSRC; k++) begin
        logic [31:0] e;
        e = m_top(0);
        claim("R8 sweep claim", 0, e);
        if (e == 0) begin
          m_force[0] = 0;
          break;
        end
        m_pend[int'(e >> 16)] = 0;
      end
      rdchk("R8 sweep force cleared", 12'h004, 32'd0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule